// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Minimum-Pulse Injection

This block compares the rising edges of a reference signal and a feedback signal, both sampled by a fast system clock, and drives two single-bit pump controls toward an external charge pump. Raising the pump-up control pushes the downstream control level higher, and raising pump-down pulls it lower. Each input passes through its own two-flop synchronizer and a rising-edge detector. A sticky flag records each detected edge. When both flags are set, both are cleared on the next clock, so the difference between the pump-up and pump-down widths equals the edge-time difference in clock cycles.

Near lock the correction can shrink to zero width. To keep that from happening, the block holds both controls high for a programmable number of cycles after every clear. This injected pulse is the same on both outputs, so it adds no net correction, and the detector never has to produce a vanishing pulse. When the two inputs run at different frequencies, the flag of the faster input stays set across several of its own edges. The frequency-correcting output therefore keeps firing and never reverses.

A lock monitor measures the raw single-flag time of each comparison. It raises a lock flag after 16 consecutive comparisons in which that time is at most one cycle, and drops the flag on the first comparison that exceeds it.

Top module: `pfd_antidz`

## Requirements
- R1: A synchronous active-high reset clears both flags, the injection counter, the lock history and the synchronizers, so that pump_up, pump_dn and locked read 0 on the cycle after reset.
- R2: When the feedback edge lags the reference edge by L cycles, pump_up is high for L+1+MIN_W cycles and pump_dn for 1+MIN_W cycles in that comparison.
- R3: When the feedback edge leads the reference edge by L cycles, pump_dn is high for L+1+MIN_W cycles and pump_up for 1+MIN_W cycles.
- R4: Coincident edges give equal widths of 1+MIN_W cycles on both outputs, which is no net correction.
- R5: After every clear, both outputs stay high for exactly MIN_W further cycles (MIN_W defaults to 2).
- R6: A rising input sampled at clock edge k raises its output after edge k+2, and each detected rise is one cycle long.
- R7: When the inputs differ in frequency, the flag of the faster input stays set until the slower edge arrives. pump_dn is never high without pump_up while the reference is faster.
- R8: locked rises on the clock edge that clears the 16th consecutive comparison whose single-flag time is at most 1 cycle. A 1-cycle difference still counts as good.
- R9: locked falls on the clock edge that clears the first comparison whose single-flag time exceeds 1 cycle.
- R10: Both flags are cleared one clock after both are set, unless new edges arrive on both inputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| pump_up | output | 1 | Raise the downstream control level |
| pump_dn | output | 1 | Lower the downstream control level |
| locked | output | 1 | Sixteen consecutive small-error comparisons seen |

## Verification
The bench drives inputs on falling edges. A behavioural model steps on every rising edge, and the outputs are compared with it on the following falling edge. A flag rises three rising edges after the input change is first sampled, and the injected pulse follows on the edge after the clear. The lock flag changes on that same clearing edge. The directed width counts therefore span whole stimulus periods that each contain the full pulse. The latency check samples exactly two and three edges after the input change, and the lock checks read the flag only at period ends, after the clear has settled.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;

    // Width needed to hold the value n (at least one bit).
    function automatic int unsigned bits_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
        rise    = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R6: a detected rise lasts a single cycle
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int MIN_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_ref,
    input  logic       rise_fb,
    output pump_pair_t pumps,
    output logic       flag_up,
    output logic       flag_dn
);
    localparam int CNT_W = bits_for(MIN_W);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_W);

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     both;
    logic     stretch_on;

    generate
        if (MIN_W == 0) begin : g_no_stretch
            assign stretch_on = 1'b0;
        end else begin : g_stretch
            assign stretch_on = (st_q.cnt != '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        both = st_q.up & st_q.dn;
        if (both) begin
            st_d.up  = rise_ref;
            st_d.dn  = rise_fb;
            st_d.cnt = LOAD;
        end else begin
            st_d.up  = st_q.up | rise_ref;
            st_d.dn  = st_q.dn | rise_fb;
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
        pumps.up = st_q.up | stretch_on;
        pumps.dn = st_q.dn | stretch_on;
        flag_up  = st_q.up;
        flag_dn  = st_q.dn;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R10: both flags clear one clock after both are set
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_up && flag_dn && !(rise_ref && rise_fb)) |=> !(flag_up && flag_dn));
    // R5: the injected pulse follows every clear on both outputs
    p_min_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_up && flag_dn && (MIN_W > 0)) |=> (pumps.up && pumps.dn));
    // R7: a lone up flag persists until a feedback edge arrives
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_up && !flag_dn && !rise_fb) |=> flag_up);

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int LOCK_N = 16,
    parameter int DIFF_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_up,
    input  logic flag_dn,
    output logic locked
);
    localparam int GOOD_W = bits_for(LOCK_N);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_N);

    typedef struct packed {
        logic [DIFF_W-1:0] diff;
        logic [GOOD_W-1:0] good;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     cmp_done;

    always_comb begin
        st_d     = st_q;
        cmp_done = flag_up & flag_dn;
        if (cmp_done) begin
            st_d.diff = '0;
            if (st_q.diff <= DIFF_W'(1)) begin
                if (st_q.good != GOOD_MAX) st_d.good = st_q.good + 1'b1;
            end else begin
                st_d.good = '0;
            end
        end else if ((flag_up ^ flag_dn) && (st_q.diff != '1)) begin
            st_d.diff = st_q.diff + 1'b1;
        end
        locked = (st_q.good == GOOD_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R9: a large-error comparison drops lock on its clearing edge
    p_lock_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && st_q.diff > DIFF_W'(1)) |=> !locked);
    // R8: lock only rises on the clear of a good comparison
    p_lock_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cmp_done && st_q.diff <= DIFF_W'(1)));

endmodule

// File: rtl/pfd_antidz.sv
module pfd_antidz
    import pfd_pkg::*;
#(
    parameter int MIN_W  = 2,
    parameter int LOCK_N = 16,
    parameter int DIFF_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic pump_up,
    output logic pump_dn,
    output logic locked
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    pump_pair_t      pumps;
    logic            flag_up, flag_dn;

    assign raw_in = {fb_in, ref_in};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_sync
            pfd_edge_sync #(.STAGES(2)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[i]),
                .rise (rise[i])
            );
        end
    endgenerate

    pfd_core #(.MIN_W(MIN_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .rise_ref (rise[0]),
        .rise_fb  (rise[1]),
        .pumps    (pumps),
        .flag_up  (flag_up),
        .flag_dn  (flag_dn)
    );

    pfd_lock_mon #(.LOCK_N(LOCK_N), .DIFF_W(DIFF_W)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .flag_up (flag_up),
        .flag_dn (flag_dn),
        .locked  (locked)
    );

    assign pump_up = pumps.up;
    assign pump_dn = pumps.dn;

    // R1: outputs idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!pump_up && !pump_dn && !locked));

endmodule

// File: tb/test_pfd_antidz.sv
`timescale 1ns/1ps
module test_pfd_antidz;
    localparam int MIN_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic pump_up, pump_dn, locked;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    pfd_antidz #(.MIN_W(MIN_W)) i_pfd_antidz (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked)
    );

    // Behavioural model: input history, pending edges, stretch time, lock history.
    int rh[3];
    int fh[3];
    bit m_up = 0, m_dn = 0;
    int m_str = 0, m_diff = 0, m_good = 0;

    always @(posedge clk) begin
        bit r_rise, f_rise;
        r_rise = (rh[1] == 1) && (rh[2] == 0);
        f_rise = (fh[1] == 1) && (fh[2] == 0);
        if (rst) begin
            rh = '{0, 0, 0}; fh = '{0, 0, 0};
            m_up = 0; m_dn = 0; m_str = 0; m_diff = 0; m_good = 0;
        end else begin
            if (m_up && m_dn) begin
                if (m_diff <= 1) m_good = (m_good < 16) ? m_good + 1 : 16;
                else             m_good = 0;
                m_diff = 0;
                m_str = MIN_W;
                m_up = r_rise;
                m_dn = f_rise;
            end else begin
                if (m_up != m_dn && m_diff < 255) m_diff++;
                if (m_str > 0) m_str--;
                m_up = m_up | r_rise;
                m_dn = m_dn | f_rise;
            end
            rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = ref_in;
            fh[2] = fh[1]; fh[1] = fh[0]; fh[0] = fb_in;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, {pump_up, pump_dn, locked},
                {(m_up || m_str > 0), (m_dn || m_str > 0), (m_good == 16)},
                "per-clock {up,dn,lock}");
        end
    end

    // One period of per cycles; ref rises at offset a, fb at offset b.
    task automatic period(int a, int b, int per, output int ucnt, output int dcnt);
        ucnt = 0; dcnt = 0;
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            ucnt += pump_up; dcnt += pump_dn;
            ref_in = (i >= a) && (i < a + per / 2);
            fb_in  = (i >= b) && (i < b + per / 2);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int u, d, viol;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {pump_up, pump_dn, locked}, 0, "outputs after reset");

        // R6: latency from input change to flag
        cur_req = "R6";
        ref_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6", pump_up, 0, "pump_up two edges after change");
        @(negedge clk);
        chk("R6", pump_up, 1, "pump_up three edges after change");
        fb_in = 1'b1;
        repeat (8) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (8) @(negedge clk);

        // R2: feedback lags by 5
        cur_req = "R2";
        period(2, 7, 24, u, d);
        chk("R2", u, 5 + 1 + MIN_W, "up width lag 5");
        chk("R2", d, 1 + MIN_W, "dn width lag 5");

        // R3: feedback leads by 4
        cur_req = "R3";
        period(6, 2, 24, u, d);
        chk("R3", d, 4 + 1 + MIN_W, "dn width lead 4");
        chk("R3", u, 1 + MIN_W, "up width lead 4");

        // R4/R5/R8: coincident periods build lock
        cur_req = "R4";
        period(3, 3, 24, u, d);
        chk("R4", u, 1 + MIN_W, "up width coincident");
        chk("R5", d, 1 + MIN_W, "dn width equals injected minimum");
        cur_req = "R8";
        for (int k = 1; k < 15; k++) period(3, 3, 24, u, d);
        chk("R8", locked, 0, "lock after 15 good comparisons");
        period(3, 3, 24, u, d);
        chk("R8", locked, 1, "lock after 16 good comparisons");
        period(3, 4, 24, u, d);
        chk("R8", locked, 1, "one-cycle difference keeps lock");
        chk("R2", u, 1 + 1 + MIN_W, "up width lag 1");

        // R9: two-cycle error drops lock
        cur_req = "R9";
        period(3, 5, 24, u, d);
        chk("R9", locked, 0, "lock lost on two-cycle error");

        // R7: reference twice the feedback frequency
        cur_req = "R7";
        u = 0; d = 0; viol = 0;
        for (int i = 0; i < 192; i++) begin
            @(negedge clk);
            u += pump_up; d += pump_dn;
            if (pump_dn && !pump_up) viol++;
            ref_in = (i % 12) < 6;
            fb_in  = ((i + 3) % 24) < 12;
        end
        chk("R7", viol, 0, "dn without up under frequency offset");
        chk("R7", (u > 2 * d) ? 1 : 0, 1, "up dominates under frequency offset");
        chk("R9", locked, 0, "no lock under frequency offset");

        // R1: reset mid-activity
        cur_req = "R1";
        ref_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", {pump_up, pump_dn, locked}, 0, "outputs during reset");
        ref_in = 1'b0;
        rst = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule